// File: doc/BRIEF.md
# Processor Cycle-Stepping Trace Controller

This block lets a host single-step an 8-bit processor one bus cycle at a time and watch what it does. The host hands it decoded command strobes with operands. A step command grants the processor a number of clock enables. For each granted cycle the block captures the bus and emits one trace record. The record holds the cycles still to run, the address, the direction, the data byte, and flags for the active-low control lines that are asserted in that cycle.

Two pulse generators can hold the processor's reset or interrupt-request line low for a set number of processor cycles. A memory writer can fill an address range with one value, or deposit bytes one after another, into the attached memory.

Records leave through a valid/ready handshake. The processor is clocked only while a run is active and the record slot is free. When the run count reaches zero the processor stays halted with its bus state held.

Top module: `cyc_trace_ctrl`

## Requirements
- R1: A step command with count N (op code 0) produces exactly N records and N processor clock enables. The record counts go N-1, N-2, ..., 0, and no further enable follows. N = 0 produces nothing.
- R2: The record count field is 10 bits wide. It shows 999 whenever the true remaining count is larger than 999.
- R3: Each record carries the 16-bit address, the direction bit (1 = read) and the 8-bit data seen on the processor bus in the cycle its clock enable was issued.
- R4: The 3-bit flag field is {reset, nmi, irq}. A bit is 1 only when that line is low in the cycle the record was captured.
- R5: A reset-pulse command (op code 1) with count P drives the reset output low from the next cycle. It holds the line low for P processor clock enables and then releases it. P = 0 leaves the line high.
- R6: An irq-pulse command (op code 2) with count P drives the irq output low in the same way as R5.
- R7: A fill command (op code 3) writes the value to every address from start to end inclusive, one write per cycle. If end is below start, nothing is written. A range ending at FFFF stops there and does not wrap.
- R8: A deposit command (op code 4) writes one byte at the given address. Each deposit-next command (op code 5) then writes its byte at the following address.
- R9: A record whose valid is high stays unchanged until ready is high. No processor clock enable is issued while a record is waiting.
- R10: While a run or a fill is in progress, step, fill, deposit and deposit-next commands are rejected, and pulse commands are still accepted. Op codes 6 and 7 are always rejected. Every command is answered in its own cycle by exactly one of accept or reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command op code |
| cmd_count_i | input | 16 | Cycle count for step and pulse commands |
| cmd_addr_i | input | 16 | Start address for fill and deposit |
| cmd_end_i | input | 16 | End address for fill |
| cmd_data_i | input | 8 | Byte for fill and deposit |
| cmd_accept_o | output | 1 | Command accepted |
| cmd_reject_o | output | 1 | Command rejected |
| cpu_step_o | output | 1 | Processor clock enable, one per traced cycle |
| cpu_addr_i | input | 16 | Processor address bus |
| cpu_rw_i | input | 1 | Processor direction, 1 = read |
| cpu_data_i | input | 8 | Processor data bus |
| cpu_nmi_ni | input | 1 | Observed non-maskable interrupt line, active low |
| cpu_res_no | output | 1 | Processor reset line, active low |
| cpu_irq_no | output | 1 | Processor interrupt request line, active low |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| trc_valid_o | output | 1 | Trace record valid |
| trc_ready_i | input | 1 | Trace consumer ready |
| trc_count_o | output | 10 | Remaining cycles, saturated |
| trc_addr_o | output | 16 | Traced address |
| trc_rw_o | output | 1 | Traced direction |
| trc_data_o | output | 8 | Traced data byte |
| trc_flags_o | output | 3 | {reset, nmi, irq} asserted flags |

## Verification
The hardest case is a pulse command landing in the middle of a run while the trace consumer is stalling. In that case the pulse counter, the record slot and the run counter all move on the same gated enable. The bench reaches it by setting ready to a repeating stall pattern and starting a long run. It then issues, mid-run, an irq pulse that must be accepted and a fill and a step that must be rejected. A scoreboard checks every record against the bench's own processor model. The bench also confirms that the held record never changes while ready is low and that no memory write appears during the run.

// File: rtl/cyc_trace_pkg.sv
package cyc_trace_pkg;
  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_RST   = 3'd1,
    OP_IRQ   = 3'd2,
    OP_FILL  = 3'd3,
    OP_DEP   = 3'd4,
    OP_DEPN  = 3'd5
  } cmd_op_e;
endpackage

// File: rtl/line_pulse.sv
module line_pulse #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             step_i,
  output logic             line_no
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= len_i;
    else if (step_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign line_no = (cnt_q == '0);

  // R5
  release_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_no) |-> $past(step_i));
endmodule

// File: rtl/step_engine.sv
module step_engine #(
  parameter int CNT_W = 16,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int SAT   = 999,
  localparam int DISP_W = $clog2(SAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_rw_i,
  input  logic [DW-1:0]     bus_data_i,
  input  logic [2:0]        flags_i,
  input  logic              trc_ready_i,
  output logic              step_o,
  output logic              active_o,
  output logic              trc_valid_o,
  output logic [DISP_W-1:0] trc_count_o,
  output logic [AW-1:0]     trc_addr_o,
  output logic              trc_rw_o,
  output logic [DW-1:0]     trc_data_o,
  output logic [2:0]        trc_flags_o
);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT);

  logic [CNT_W-1:0] left_q, left_m1;

  assign active_o = (left_q != '0);
  assign step_o   = active_o && (!trc_valid_o || trc_ready_i);
  assign left_m1  = left_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (start_i) left_q <= len_i;
    else if (step_o)  left_q <= left_m1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trc_valid_o <= 1'b0;
      trc_count_o <= '0;
      trc_addr_o  <= '0;
      trc_rw_o    <= 1'b0;
      trc_data_o  <= '0;
      trc_flags_o <= '0;
    end else if (step_o) begin
      trc_valid_o <= 1'b1;
      trc_count_o <= (left_m1 > SAT_C) ? DISP_W'(SAT) : left_m1[DISP_W-1:0];
      trc_addr_o  <= bus_addr_i;
      trc_rw_o    <= bus_rw_i;
      trc_data_o  <= bus_data_i;
      trc_flags_o <= flags_i;
    end else if (trc_ready_i) begin
      trc_valid_o <= 1'b0;
    end
  end

  // R9
  hold_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o && !trc_ready_i |=> trc_valid_o && $stable(trc_addr_o)
      && $stable(trc_count_o) && $stable(trc_data_o) && $stable(trc_flags_o));
  // R2
  count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o |-> trc_count_o <= DISP_W'(SAT));
  // R1
  last_record_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) && !$past(start_i) |-> trc_valid_o && trc_count_o == '0);
endmodule

// File: rtl/mem_writer.sv
module mem_writer #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_i,
  input  logic          dep_i,
  input  logic          depn_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic [AW-1:0] cur_q, end_q;
  logic [DW-1:0] val_q;
  logic          fill_q, dep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0; end_q <= '0; val_q <= '0; fill_q <= 1'b0; dep_q <= 1'b0;
    end else if (fill_i) begin
      cur_q  <= start_i;
      end_q  <= end_i;
      val_q  <= data_i;
      fill_q <= (end_i >= start_i);
      dep_q  <= 1'b0;
    end else if (dep_i) begin
      cur_q <= start_i;
      val_q <= data_i;
      dep_q <= 1'b1;
    end else if (depn_i) begin
      cur_q <= cur_q + 1'b1;
      val_q <= data_i;
      dep_q <= 1'b1;
    end else begin
      dep_q <= 1'b0;
      if (fill_q) begin
        if (cur_q == end_q) fill_q <= 1'b0;
        else                cur_q  <= cur_q + 1'b1;
      end
    end
  end

  assign busy_o = fill_q;
  assign we_o   = fill_q | dep_q;
  assign addr_o = cur_q;
  assign data_o = val_q;

  // R7
  fill_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q |-> cur_q <= end_q);
endmodule

// File: rtl/cyc_trace_ctrl.sv
module cyc_trace_ctrl
  import cyc_trace_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int SAT   = 999,
  localparam int DISP_W = $clog2(SAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic [AW-1:0]     cmd_addr_i,
  input  logic [AW-1:0]     cmd_end_i,
  input  logic [DW-1:0]     cmd_data_i,
  output logic              cmd_accept_o,
  output logic              cmd_reject_o,
  output logic              cpu_step_o,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic              cpu_rw_i,
  input  logic [DW-1:0]     cpu_data_i,
  input  logic              cpu_nmi_ni,
  output logic              cpu_res_no,
  output logic              cpu_irq_no,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              trc_valid_o,
  input  logic              trc_ready_i,
  output logic [DISP_W-1:0] trc_count_o,
  output logic [AW-1:0]     trc_addr_o,
  output logic              trc_rw_o,
  output logic [DW-1:0]     trc_data_o,
  output logic [2:0]        trc_flags_o
);
  logic run_active, fill_busy, idle, is_pulse, is_busop;
  logic go_step, go_rst, go_irq, go_fill, go_dep, go_depn;
  logic [2:0] flags;

  assign idle     = !run_active && !fill_busy;
  assign is_pulse = (cmd_op_i == OP_RST) || (cmd_op_i == OP_IRQ);
  assign is_busop = (cmd_op_i == OP_STEP) || (cmd_op_i == OP_FILL)
                 || (cmd_op_i == OP_DEP)  || (cmd_op_i == OP_DEPN);

  assign cmd_accept_o = cmd_valid_i && (is_pulse || (is_busop && idle));
  assign cmd_reject_o = cmd_valid_i && !cmd_accept_o;

  assign go_step = cmd_accept_o && cmd_op_i == OP_STEP;
  assign go_rst  = cmd_accept_o && cmd_op_i == OP_RST;
  assign go_irq  = cmd_accept_o && cmd_op_i == OP_IRQ;
  assign go_fill = cmd_accept_o && cmd_op_i == OP_FILL;
  assign go_dep  = cmd_accept_o && cmd_op_i == OP_DEP;
  assign go_depn = cmd_accept_o && cmd_op_i == OP_DEPN;

  line_pulse #(.CNT_W(CNT_W)) i_res_pulse (
    .clk_i, .rst_ni, .load_i(go_rst), .len_i(cmd_count_i),
    .step_i(cpu_step_o), .line_no(cpu_res_no)
  );

  line_pulse #(.CNT_W(CNT_W)) i_irq_pulse (
    .clk_i, .rst_ni, .load_i(go_irq), .len_i(cmd_count_i),
    .step_i(cpu_step_o), .line_no(cpu_irq_no)
  );

  assign flags = {!cpu_res_no, !cpu_nmi_ni, !cpu_irq_no};

  step_engine #(.CNT_W(CNT_W), .AW(AW), .DW(DW), .SAT(SAT)) i_step (
    .clk_i, .rst_ni,
    .start_i(go_step), .len_i(cmd_count_i),
    .bus_addr_i(cpu_addr_i), .bus_rw_i(cpu_rw_i), .bus_data_i(cpu_data_i),
    .flags_i(flags), .trc_ready_i,
    .step_o(cpu_step_o), .active_o(run_active),
    .trc_valid_o, .trc_count_o, .trc_addr_o, .trc_rw_o, .trc_data_o, .trc_flags_o
  );

  mem_writer #(.AW(AW), .DW(DW)) i_mem (
    .clk_i, .rst_ni,
    .fill_i(go_fill), .dep_i(go_dep), .depn_i(go_depn),
    .start_i(cmd_addr_i), .end_i(cmd_end_i), .data_i(cmd_data_i),
    .busy_o(fill_busy), .we_o(mem_we_o), .addr_o(mem_addr_o), .data_o(mem_wdata_o)
  );

  // R10
  run_fill_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_active && fill_busy));
  // R10
  one_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> $onehot({cmd_accept_o, cmd_reject_o}));
  // R7
  no_write_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_step_o |-> !fill_busy);
endmodule

// File: tb/test_cyc_trace_ctrl.sv
module test_cyc_trace_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_count = '0, cmd_addr = '0, cmd_end = '0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_accept, cmd_reject, cpu_step, cpu_res_n, cpu_irq_n;
  logic        nmi_n = 1'b1;
  logic        mem_we, trc_valid, trc_rw;
  logic        trc_ready = 1'b1;
  logic [15:0] mem_addr, trc_addr;
  logic [7:0]  mem_wdata, trc_data;
  logic [9:0]  trc_count;
  logic [2:0]  trc_flags;

  int unsigned mcnt = 0;
  logic [15:0] bus_addr;
  logic        bus_rw;
  logic [7:0]  bus_data;
  assign bus_addr = 16'h2000 + mcnt[15:0];
  assign bus_rw   = ~mcnt[0];
  assign bus_data = mcnt[7:0] ^ 8'h3c;
  always @(posedge clk) if (cpu_step) mcnt <= mcnt + 1;

  cyc_trace_ctrl i_cyc_trace_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_count_i(cmd_count),
    .cmd_addr_i(cmd_addr), .cmd_end_i(cmd_end), .cmd_data_i(cmd_data),
    .cmd_accept_o(cmd_accept), .cmd_reject_o(cmd_reject),
    .cpu_step_o(cpu_step), .cpu_addr_i(bus_addr), .cpu_rw_i(bus_rw),
    .cpu_data_i(bus_data), .cpu_nmi_ni(nmi_n),
    .cpu_res_no(cpu_res_n), .cpu_irq_no(cpu_irq_n),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .trc_valid_o(trc_valid), .trc_ready_i(trc_ready), .trc_count_o(trc_count),
    .trc_addr_o(trc_addr), .trc_rw_o(trc_rw), .trc_data_o(trc_data),
    .trc_flags_o(trc_flags)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard: {count, addr, rw, data, flags}
  logic [37:0] q[$];
  logic [2:0]  fmask = 3'b111;
  bit          stall_mode = 1'b0;
  int          tick = 0;

  always @(posedge clk) begin
    #1;
    tick++;
    trc_ready = stall_mode ? (tick % 3 != 0) : 1'b1;
  end

  logic [7:0]  bmem [0:511];
  int          wcount = 0;
  logic [15:0] last_waddr = '0;
  logic        hold_pend = 1'b0;
  logic [37:0] held;

  always @(negedge clk) begin
    logic [37:0] cur, e;
    cur = {trc_count, trc_addr, trc_rw, trc_data, trc_flags};
    if (rst_n && hold_pend) begin
      // R9: record stays put while stalled
      chk(trc_valid && cur == held, "R9 held record", cur, held);
      chk(!cpu_step || trc_ready, "R9 step while waiting", cpu_step, 0);
    end
    hold_pend = rst_n && trc_valid && !trc_ready;
    held = cur;
    if (rst_n && trc_valid && trc_ready) begin
      if (q.size() == 0) chk(0, "R1 extra record", cur, 0);
      else begin
        e = q.pop_front();
        chk(cur[37:28] == e[37:28], "R1/R2 count", cur[37:28], e[37:28]);
        chk(cur[27:3] == e[27:3], "R3 addr/rw/data", cur[27:3], e[27:3]);
        chk((cur[2:0] & fmask) == (e[2:0] & fmask), "R4 flags", cur[2:0], e[2:0]);
      end
    end
    if (rst_n && mem_we) begin
      bmem[mem_addr[8:0]] = mem_wdata;
      wcount++;
      last_waddr = mem_addr;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [15:0] cnt, input logic [15:0] a,
                       input logic [15:0] e, input logic [7:0] d, output bit acc);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt; cmd_addr = a; cmd_end = e; cmd_data = d;
    @(negedge clk);
    acc = cmd_accept;
    chk(cmd_accept ^ cmd_reject, "R10 one answer", {cmd_accept, cmd_reject}, 0);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic push_run(input int n, input int pr, input int pi, input bit nmi);
    for (int i = 0; i < n; i++) begin
      int unsigned m = mcnt + i;
      int left = n - 1 - i;
      logic [9:0]  c = (left > 999) ? 10'd999 : 10'(left);
      logic [15:0] ad = 16'h2000 + m[15:0];
      q.push_back({c, ad, ~m[0], m[7:0] ^ 8'h3c, (i < pr), nmi, (i < pi)});
    end
  endtask

  task automatic drain();
    while (q.size() != 0 || trc_valid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit acc;
    int unsigned m0;
    int w0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!trc_valid && !cpu_step && !mem_we, "R1 reset idle", {trc_valid, cpu_step, mem_we}, 0);
    chk(cpu_res_n && cpu_irq_n, "R5 reset lines high", {cpu_res_n, cpu_irq_n}, 3);
    rst_n = 1'b1;

    // R1 R3: plain run
    m0 = mcnt;
    push_run(6, 0, 0, 0);
    issue(0, 16'd6, 0, 0, 0, acc);
    chk(acc, "R1 step accepted", acc, 1);
    drain();
    chk(mcnt == m0 + 6, "R1 enable count", mcnt - m0, 6);

    // R1: zero count
    m0 = mcnt;
    issue(0, 16'd0, 0, 0, 0, acc);
    repeat (5) @(negedge clk);
    chk(mcnt == m0 && !trc_valid, "R1 zero run", mcnt - m0, 0);

    // R5 R6 R4: pulses before run, nmi held low
    issue(1, 16'd3, 0, 0, 0, acc);
    chk(acc && !cpu_res_n, "R5 reset low", cpu_res_n, 0);
    issue(2, 16'd5, 0, 0, 0, acc);
    chk(acc && !cpu_irq_n, "R6 irq low", cpu_irq_n, 0);
    nmi_n = 1'b0;
    push_run(8, 3, 5, 1);
    issue(0, 16'd8, 0, 0, 0, acc);
    drain();
    nmi_n = 1'b1;
    chk(cpu_res_n, "R5 reset released", cpu_res_n, 1);
    chk(cpu_irq_n, "R6 irq released", cpu_irq_n, 1);
    issue(1, 16'd0, 0, 0, 0, acc);
    @(negedge clk);
    chk(cpu_res_n, "R5 zero pulse", cpu_res_n, 1);

    // R9 R10: stalled run with commands mid-run
    stall_mode = 1'b1;
    fmask = 3'b110;
    w0 = wcount;
    push_run(40, 0, 0, 0);
    issue(0, 16'd40, 0, 0, 0, acc);
    repeat (5) @(negedge clk);
    issue(3, 16'd0, 16'h0100, 16'h0110, 8'h99, acc);
    chk(!acc, "R10 fill rejected in run", acc, 0);
    issue(0, 16'd5, 0, 0, 0, acc);
    chk(!acc, "R10 step rejected in run", acc, 0);
    issue(4, 16'd0, 16'h0100, 0, 8'h11, acc);
    chk(!acc, "R10 deposit rejected in run", acc, 0);
    issue(2, 16'd2, 0, 0, 0, acc);
    chk(acc, "R10 irq accepted in run", acc, 1);
    drain();
    chk(wcount == w0, "R10 no write in run", wcount - w0, 0);
    stall_mode = 1'b0;
    fmask = 3'b111;
    chk(cpu_irq_n, "R6 mid-run pulse released", cpu_irq_n, 1);

    // R2: saturation
    push_run(1200, 0, 0, 0);
    issue(0, 16'd1200, 0, 0, 0, acc);
    drain();
    chk(q.size() == 0, "R2 all records", q.size(), 0);

    // R7: fill
    w0 = wcount;
    issue(3, 0, 16'h0100, 16'h011f, 8'h77, acc);
    issue(4, 0, 16'h0100, 0, 8'h11, acc);
    chk(!acc, "R10 deposit rejected in fill", acc, 0);
    repeat (40) @(negedge clk);
    chk(wcount - w0 == 32, "R7 fill writes", wcount - w0, 32);
    chk(bmem[9'h100] == 8'h77 && bmem[9'h11f] == 8'h77, "R7 fill ends", bmem[9'h11f], 8'h77);
    chk(last_waddr == 16'h011f, "R7 last addr", last_waddr, 16'h011f);
    w0 = wcount;
    issue(3, 0, 16'h0130, 16'h012f, 8'h88, acc);
    repeat (5) @(negedge clk);
    chk(wcount == w0, "R7 empty range", wcount - w0, 0);
    w0 = wcount;
    issue(3, 0, 16'hfff0, 16'hffff, 8'h55, acc);
    repeat (25) @(negedge clk);
    chk(wcount - w0 == 16 && last_waddr == 16'hffff, "R7 top of range", wcount - w0, 16);

    // R8: deposit
    issue(4, 0, 16'h0150, 0, 8'ha1, acc);
    issue(5, 0, 0, 0, 8'ha2, acc);
    issue(5, 0, 0, 0, 8'ha3, acc);
    repeat (3) @(negedge clk);
    chk(bmem[9'h150] == 8'ha1, "R8 deposit", bmem[9'h150], 8'ha1);
    chk(bmem[9'h151] == 8'ha2 && bmem[9'h152] == 8'ha3, "R8 deposit next",
        {bmem[9'h151], bmem[9'h152]}, 16'ha2a3);

    // R10: reserved op codes
    issue(6, 0, 0, 0, 0, acc);
    chk(!acc, "R10 op6 rejected", acc, 0);
    issue(7, 0, 0, 0, 0, acc);
    chk(!acc, "R10 op7 rejected", acc, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule